// File: doc/BRIEF.md
# Ring Buffer Sync Marker Tracker

This block sits on the receive side of a frame-based link between two processors. The sending side interleaves audio with a synchronisation channel, and once per processing cycle it plants a fixed 24-bit marker word, 0xEDC987, at a known offset of its transmit ring. On every cycle-start strobe the tracker reads the receive ring at its current read pointer plus that offset. If the word there is the marker, the link is locked and the pointer stays where it is. If it is not, the tracker hunts forward through the ring one frame stride at a time. When it finds the marker, it moves the read pointer by the measured drift. If the search budget runs out, it raises a lost flag and tries again on the next strobe.

Every strobe that the tracker accepts also writes the marker back into the transmit buffer at the acknowledge offset, so the far side can see that the receiver is alive. Both memory ports are valid/ready streams with at most one transaction in flight. A read request holds `rd_valid` and `rd_addr` steady until `rd_ready` is high at a clock edge. The response comes back on `rsp_valid`/`rsp_data` with any latency and cannot be back-pressured. An acknowledge write holds `wr_valid`, `wr_addr` and `wr_data` until `wr_ready` is high. A downstream extractor uses `rd_ptr` as its frame base. Ring addresses wrap modulo `DEPTH`, which must be a power of two, and `STRIDE` is a power of two no larger than `DEPTH`.

Top module: `sync_marker_tracker`

## Requirements
- R1: After reset, `locked`, `searching`, `lost` and `overrun` are 0, `rd_ptr` is 0, and neither `rd_valid` nor `wr_valid` is asserted.
- R2: A strobe is accepted only when the tracker is idle and no acknowledge write is pending. An accepted strobe issues one read at address (`rd_ptr` + `MARK_OFS`) mod `DEPTH`, where `MARK_OFS` defaults to 11. If that read returns 0xEDC987, `locked` is set, `rd_ptr` is unchanged and no further read follows.
- R3: On a mismatch, `searching` is set, `locked` and `lost` are cleared, and the next read goes `STRIDE` words further on, wrapping modulo `DEPTH`. `STRIDE` defaults to 16.
- R4: When search step k (1 ≤ k ≤ `MAX_STEPS`) returns the marker, `rd_ptr` becomes (`rd_ptr` + k·`STRIDE`) mod `DEPTH`, `locked` is set, `searching` is cleared, and the check takes exactly k+1 reads.
- R5: When none of the `MAX_STEPS` search reads returns the marker, `lost` is set and `rd_ptr` is unchanged after exactly `MAX_STEPS`+1 reads. The next accepted strobe searches again.
- R6: Each accepted strobe produces exactly one write of 0xEDC987 to transmit address `ACK_OFS`, which defaults to 5.
- R7: `rd_valid` and `rd_addr` stay stable while `rd_ready` is low, and no new read request is raised while a response is outstanding.
- R8: `wr_valid`, `wr_addr` and `wr_data` stay stable while `wr_ready` is low. The search proceeds regardless of a stalled write.
- R9: A strobe that arrives while a search is in progress or an acknowledge is pending causes no read and no write, and it sets `overrun`. The next accepted strobe clears `overrun`.
- R10: At most one of `locked`, `searching` and `lost` is high at any time. All three hold their values between checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-cycle strobe per processing cycle |
| rd_valid | output | 1 | Receive ring read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | $clog2(DEPTH) | Receive ring word address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 24 | Read data word |
| wr_valid | output | 1 | Acknowledge write valid |
| wr_ready | input | 1 | Acknowledge write accepted |
| wr_addr | output | $clog2(TX_BLOCK) | Transmit buffer word address |
| wr_data | output | 24 | Acknowledge word |
| rd_ptr | output | $clog2(DEPTH) | Corrected receive read pointer |
| locked | output | 1 | Marker found at the expected or a corrected position |
| searching | output | 1 | Hunt in progress |
| lost | output | 1 | Last hunt exhausted its budget |
| overrun | output | 1 | A strobe was dropped because the tracker was busy |

## Verification
Two events can land on the same clock edge: the final search response, which commits a pointer correction or declares loss, and a fresh cycle-start strobe. The bench memory model raises the strobe in exactly the cycle in which it delivers the last response of an exhausted search. The expected outcome is that the strobe is dropped: `overrun` goes high, the read and write counts match a single check, and `lost` stands. A second overlap stalls the acknowledge write while a check runs. The bench then judges that locking completes with the write still held, and that a strobe arriving in that window counts as an overrun.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int unsigned WORD_W = 24;
  localparam logic [WORD_W-1:0] SYNC_WORD = 24'hEDC987;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic locked;
    logic searching;
    logic lost;
  } link_status_t;
endpackage

// File: rtl/smt_addr_gen.sv
// Holds the corrected frame base and the running search offset.
module smt_addr_gen #(
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned STRIDE   = 16,
  parameter int unsigned MARK_OFS = 11,
  localparam int unsigned PW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          commit,
  output logic [PW-1:0] rd_addr,
  output logic [PW-1:0] rd_ptr
);
  localparam logic [PW-1:0] MARK_A   = PW'(MARK_OFS);
  localparam logic [PW-1:0] STRIDE_A = PW'(STRIDE);

  logic [PW-1:0] base_q;
  logic [PW-1:0] offs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      offs_q <= '0;
    end else begin
      if (start)       offs_q <= '0;
      else if (step)   offs_q <= offs_q + STRIDE_A;
      if (commit)      base_q <= base_q + offs_q;
    end
  end

  always_comb begin
    rd_addr = base_q + MARK_A + offs_q;
    rd_ptr  = base_q;
  end
endmodule

// File: rtl/smt_seq.sv
// Check-and-hunt sequencer: one read in flight, one word per response.
module smt_seq
  import smt_pkg::*;
#(
  parameter int unsigned MAX_STEPS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              step,
  output logic              commit,
  output link_status_t      status
);
  localparam int unsigned CW = $clog2(MAX_STEPS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_STEPS);

  seq_state_e    state;
  logic [CW-1:0] steps;
  logic          resp, hit, at_limit;

  always_comb begin
    resp     = (state == ST_WAIT) && rsp_valid;
    hit      = (rsp_data == SYNC_WORD);
    at_limit = (steps == LIMIT);
    commit   = resp && hit;
    step     = resp && !hit && !at_limit;
    rd_valid = (state == ST_REQ);
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      steps  <= '0;
      status <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state <= ST_REQ;
            steps <= '0;
          end
        end
        ST_REQ: begin
          if (rd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (hit) begin
              status <= '{locked: 1'b1, searching: 1'b0, lost: 1'b0};
              state  <= ST_IDLE;
            end else if (at_limit) begin
              status <= '{locked: 1'b0, searching: 1'b0, lost: 1'b1};
              state  <= ST_IDLE;
            end else begin
              status <= '{locked: 1'b0, searching: 1'b1, lost: 1'b0};
              steps  <= steps + 1'b1;
              state  <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smt_ack.sv
// Acknowledge writer: one held write per accepted strobe.
module smt_ack
  import smt_pkg::*;
#(
  parameter int unsigned TX_BLOCK = 36,
  parameter int unsigned ACK_OFS  = 5,
  localparam int unsigned TW      = $clog2(TX_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [TW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (fire)               pend_q <= 1'b1;
    else if (pend_q && wr_ready) pend_q <= 1'b0;
  end

  always_comb begin
    wr_valid = pend_q;
    wr_addr  = TW'(ACK_OFS);
    wr_data  = SYNC_WORD;
  end
endmodule

// File: rtl/sync_marker_tracker.sv
module sync_marker_tracker
  import smt_pkg::*;
#(
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned STRIDE    = 16,
  parameter int unsigned MARK_OFS  = 11,
  parameter int unsigned ACK_OFS   = 5,
  parameter int unsigned TX_BLOCK  = 36,
  parameter int unsigned MAX_STEPS = 512,
  localparam int unsigned PW       = $clog2(DEPTH),
  localparam int unsigned TW       = $clog2(TX_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PW-1:0]     rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [TW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [PW-1:0]     rd_ptr,
  output logic              locked,
  output logic              searching,
  output logic              lost,
  output logic              overrun
);
  logic         seq_busy, step, commit, accept;
  link_status_t status;

  assign accept = cycle_start && !seq_busy && !wr_valid;

  smt_seq #(.MAX_STEPS(MAX_STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (accept),
    .rd_ready (rd_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rd_valid (rd_valid),
    .busy     (seq_busy),
    .step     (step),
    .commit   (commit),
    .status   (status)
  );

  smt_addr_gen #(.DEPTH(DEPTH), .STRIDE(STRIDE), .MARK_OFS(MARK_OFS)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .step   (step),
    .commit (commit),
    .rd_addr(rd_addr),
    .rd_ptr (rd_ptr)
  );

  smt_ack #(.TX_BLOCK(TX_BLOCK), .ACK_OFS(ACK_OFS)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (accept),
    .wr_ready(wr_ready),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (accept)      overrun <= 1'b0;
    else if (cycle_start) overrun <= 1'b1;
  end

  always_comb begin
    locked    = status.locked;
    searching = status.searching;
    lost      = status.lost;
  end
endmodule

// File: rtl/smt_chk.sv
module smt_chk
  import smt_pkg::*;
#(
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned STRIDE    = 16,
  parameter int unsigned MARK_OFS  = 11,
  parameter int unsigned ACK_OFS   = 5,
  parameter int unsigned TX_BLOCK  = 36,
  parameter int unsigned MAX_STEPS = 512,
  localparam int unsigned PW       = $clog2(DEPTH),
  localparam int unsigned TW       = $clog2(TX_BLOCK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cycle_start,
  input logic              accept,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [PW-1:0]     rd_addr,
  input logic              rsp_valid,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [TW-1:0]     wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [PW-1:0]     rd_ptr,
  input logic              locked,
  input logic              searching,
  input logic              lost,
  input logic              overrun
);
  logic          outst;
  int unsigned   reads;
  logic [PW-1:0] prev_ptr, ptr_diff, exp_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst    <= 1'b0;
      reads    <= 0;
      prev_ptr <= '0;
    end else begin
      prev_ptr <= rd_ptr;
      if (rd_valid && rd_ready) outst <= 1'b1;
      else if (rsp_valid)       outst <= 1'b0;
      if (accept)                    reads <= 0;
      else if (rd_valid && rd_ready) reads <= reads + 1;
    end
  end

  always_comb begin
    ptr_diff  = rd_ptr - prev_ptr;
    exp_first = rd_ptr + PW'(MARK_OFS);
  end

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_valid && (rd_addr == $past(exp_first)));
  assert_read_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reads <= MAX_STEPS + 1);
  assert_ptr_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != prev_ptr) |-> locked && ((ptr_diff % STRIDE) == 0));
  assert_ack_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_valid);
  assert_ack_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data == SYNC_WORD) && (wr_addr == TW'(ACK_OFS)));
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !outst);
  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  assert_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start && !accept |=> overrun);
  assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({locked, searching, lost}));
endmodule

bind sync_marker_tracker smt_chk #(
  .DEPTH(DEPTH), .STRIDE(STRIDE), .MARK_OFS(MARK_OFS),
  .ACK_OFS(ACK_OFS), .TX_BLOCK(TX_BLOCK), .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .accept(accept),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rsp_valid(rsp_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_ptr(rd_ptr),
  .locked(locked), .searching(searching), .lost(lost), .overrun(overrun)
);

// File: tb/sim_sync_marker_tracker.sv
`timescale 1ns/1ps
module sim_sync_marker_tracker;
  localparam int DEPTH = 64, STRIDE = 16, MARK_OFS = 11, ACK_OFS = 5;
  localparam int TX_BLOCK = 36, MAX_STEPS = 3;
  localparam int PW = $clog2(DEPTH), TW = $clog2(TX_BLOCK);
  localparam logic [23:0] SYNC = 24'hEDC987;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic strobe_tb = 1'b0, strobe_mem = 1'b0;
  logic cycle_start;
  logic rd_valid, rd_ready = 1'b1, rsp_valid = 1'b0;
  logic [PW-1:0] rd_addr, rd_ptr;
  logic [23:0] rsp_data = '0, wr_data;
  logic wr_valid, wr_ready = 1'b1;
  logic [TW-1:0] wr_addr;
  logic locked, searching, lost, overrun;

  assign cycle_start = strobe_tb | strobe_mem;

  sync_marker_tracker #(
    .DEPTH(DEPTH), .STRIDE(STRIDE), .MARK_OFS(MARK_OFS), .ACK_OFS(ACK_OFS),
    .TX_BLOCK(TX_BLOCK), .MAX_STEPS(MAX_STEPS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .locked(locked), .searching(searching), .lost(lost),
    .overrun(overrun)
  );

  logic [23:0] mem [DEPTH];
  int lat = 0;
  bit stall = 0;
  int rsp_n = 0;
  int collide_at = -1;
  bit acc = 0, pend = 0;
  int dly = 0;
  logic [PW-1:0] acc_addr, paddr;
  int rd_hs = 0, wr_hs = 0;
  logic [TW-1:0] last_wa = '0;
  logic [23:0] last_wd = '0;
  bit seen = 0, clr_seen = 0;

  // Edge observer: handshakes and the searching flag.
  always @(posedge clk) begin
    acc      <= rd_valid && rd_ready;
    acc_addr <= rd_addr;
    if (rd_valid && rd_ready) rd_hs <= rd_hs + 1;
    if (wr_valid && wr_ready) begin
      wr_hs   <= wr_hs + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
    if (clr_seen)       seen <= 0;
    else if (searching) seen <= 1;
  end

  // Receive ring model, driven away from the active edge.
  always @(negedge clk) begin
    rsp_valid  = 1'b0;
    strobe_mem = 1'b0;
    if (acc) begin
      pend  = 1;
      dly   = lat;
      paddr = acc_addr;
    end
    if (pend) begin
      if (dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem[paddr];
        pend      = 0;
        rsp_n++;
        if (rsp_n == collide_at) strobe_mem = 1'b1;
      end else begin
        dly--;
      end
    end
    rd_ready = stall ? ~rd_ready : 1'b1;
  end

  int checks = 0, errors = 0;
  int p = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    strobe_tb = 1'b1;
    @(negedge clk);
    strobe_tb = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic run_case(input int m, input bit present);
    int r0, w0, d, k, exp_reads;
    bit hit;
    clear_mem();
    if (present) mem[m] = SYNC;
    clr_seen = 1;
    @(negedge clk);
    clr_seen = 0;
    r0 = rd_hs;
    w0 = wr_hs;
    pulse();
    tick(80);
    d   = (m - p - MARK_OFS) & (DEPTH - 1);
    hit = present && ((d % STRIDE) == 0);
    k   = d / STRIDE;
    if (hit) begin
      exp_reads = k + 1;
      p = (p + d) & (DEPTH - 1);
    end else begin
      exp_reads = MAX_STEPS + 1;
    end
    chk(locked == hit, hit ? "R2" : "R5", "locked", locked, hit);
    chk(lost == !hit, "R5", "lost", lost, !hit);
    chk(searching == 1'b0, "R10", "searching idle", searching, 0);
    chk(rd_ptr == p[PW-1:0], hit ? "R4" : "R5", "rd_ptr", rd_ptr, p);
    chk(rd_hs - r0 == exp_reads, hit ? "R4" : "R5", "reads", rd_hs - r0, exp_reads);
    chk(seen == (!hit || k > 0), "R3", "searching seen", seen, !hit || k > 0);
    chk(wr_hs - w0 == 1, "R6", "ack writes", wr_hs - w0, 1);
    chk(last_wa == TW'(ACK_OFS), "R6", "ack addr", last_wa, ACK_OFS);
    chk(last_wd == SYNC, "R6", "ack word", last_wd, SYNC);
    chk(overrun == 1'b0, "R9", "overrun clear", overrun, 0);
  endtask

  initial begin
    clear_mem();
    fork
      begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(!locked && !searching && !lost, "R1", "status",
            {locked, searching, lost}, 0);
        chk(overrun == 1'b0, "R1", "overrun", overrun, 0);
        chk(rd_ptr == '0, "R1", "rd_ptr", rd_ptr, 0);
        chk(!rd_valid && !wr_valid, "R1", "valids", {rd_valid, wr_valid}, 0);

        // Sweep every marker slot under every latency / ready pattern
        for (int m = 0; m < DEPTH; m++) begin
          for (int cfg = 0; cfg < 4; cfg++) begin
            lat   = cfg & 1;
            stall = cfg[1];
            run_case(m, 1'b1);
          end
        end
        lat = 0; stall = 0;
        run_case(0, 1'b0);

        // Every search depth, including the last allowed step (R4 boundary)
        for (int s = 0; s < 2; s++) begin
          stall = s[0];
          for (int k = 0; k <= MAX_STEPS; k++)
            run_case((p + MARK_OFS + k * STRIDE) & (DEPTH - 1), 1'b1);
        end
        stall = 0;

        // R9: strobe in the middle of a search
        begin
          int r0, w0;
          clear_mem();
          r0 = rd_hs; w0 = wr_hs;
          pulse(); tick(2); pulse(); tick(80);
          chk(overrun == 1'b1, "R9", "overrun mid-search", overrun, 1);
          chk(rd_hs - r0 == MAX_STEPS + 1, "R9", "reads", rd_hs - r0, MAX_STEPS + 1);
          chk(wr_hs - w0 == 1, "R9", "writes", wr_hs - w0, 1);
          chk(lost == 1'b1, "R5", "lost", lost, 1);
        end
        run_case(5, 1'b0);

        // R9: strobe on the very edge that delivers the final response
        begin
          int r0, w0;
          clear_mem();
          r0 = rd_hs; w0 = wr_hs;
          collide_at = rsp_n + MAX_STEPS + 1;
          pulse(); tick(80);
          collide_at = -1;
          chk(overrun == 1'b1, "R9", "overrun at final response", overrun, 1);
          chk(rd_hs - r0 == MAX_STEPS + 1, "R9", "reads", rd_hs - r0, MAX_STEPS + 1);
          chk(wr_hs - w0 == 1, "R9", "writes", wr_hs - w0, 1);
          chk(lost == 1'b1, "R5", "lost", lost, 1);
        end

        // R8: stalled acknowledge while the check completes
        begin
          int r0, w0, m;
          wr_ready = 1'b0;
          clear_mem();
          m = (p + MARK_OFS) & (DEPTH - 1);
          mem[m] = SYNC;
          r0 = rd_hs; w0 = wr_hs;
          pulse(); tick(80);
          chk(locked == 1'b1, "R8", "locked with write stalled", locked, 1);
          chk(wr_valid == 1'b1, "R8", "wr_valid held", wr_valid, 1);
          chk(wr_addr == TW'(ACK_OFS), "R8", "wr_addr held", wr_addr, ACK_OFS);
          chk(wr_hs - w0 == 0, "R8", "no write yet", wr_hs - w0, 0);
          pulse(); tick(5);
          chk(overrun == 1'b1, "R9", "overrun on pending ack", overrun, 1);
          chk(rd_hs - r0 == 1, "R9", "no extra read", rd_hs - r0, 1);
          wr_ready = 1'b1;
          tick(3);
          chk(wr_hs - w0 == 1, "R6", "single ack after release", wr_hs - w0, 1);
          chk(wr_valid == 1'b0, "R8", "wr_valid dropped", wr_valid, 0);
        end
        run_case((p + MARK_OFS) & (DEPTH - 1), 1'b1);
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule